// File: doc/BRIEF.md
# Two-Way Set-Associative Byte Cache

This block is a small data cache placed between a processor request port and a plain main-memory port. The processor issues byte reads and byte writes. The cache keeps 32-bit lines in two ways per set, looks a request up in both ways of its set at once, and answers a read hit on the next cycle without touching memory. On a miss it picks a victim with one recency bit per set, writes that victim out first if it holds modified data, fetches the whole line, and then completes the request.

Two level inputs choose the policy while the block runs. One sends every access straight to memory, leaving the stored lines alone. The other chooses between deferring writes until eviction and copying each write to memory at once. Two one-cycle commands empty the cache. One drops every line and discards modified data. The other first copies every modified line to memory and then drops them all. The number of set-index bits is a parameter, so a small instance can stand in for a large one.

Top module: `tsac_cache`

## Requirements
- R1: A byte address is split, from least to most significant, into a 2-bit byte offset, a SET_W-bit set index and a tag made of the remaining bits. A read returns byte `offset` of the 32-bit line, where byte 0 is bits 7:0. The same tag in a different set is a different line.
- R2: A read that hits is accepted with `cpu_ready` high. It raises `rsp_valid` with the byte on the next cycle. It causes no memory access, and `cpu_ready` stays high.
- R3: A miss drops `cpu_ready` from the cycle after acceptance until the request completes. It fetches the line with one memory read of all four bytes. The two ways of a set never both match one address.
- R4: Each set remembers which way was referenced last, on hits, on fills and on write hits. A miss replaces the other way. After reset, way 0 counts as last used.
- R5: In write-back mode (`ctl_wback`=1), a write that hits updates only the cached byte and marks the line modified. It issues no memory access.
- R6: When a miss picks a modified victim, the victim is written to memory at its own line address with all four byte enables set. This happens before the fill read.
- R7: In write-through mode (`ctl_wback`=0), every write, hit or miss, issues one memory write whose only byte enable is bit `offset`. A write miss first fills the line.
- R8: With `ctl_disable`=1, every read and every write makes exactly one memory access and the cache is not consulted. A repeated read of one address therefore makes a memory read each time.
- R9: `cmd_inval` clears every valid bit in one cycle without any memory write. Modified data is lost, so a later read returns the memory contents.
- R10: `cmd_flush` writes every modified line to memory, one write per line, with clean lines not written. It then clears every valid bit. `cpu_ready` is low until it finishes. `cmd_flush` wins when both commands are high.
- R11: After reset `cpu_ready` is high, `mem_req` and `rsp_valid` are low, and no line is valid.
- R12: Once `mem_req` is raised, it, `mem_we` and `mem_addr` hold until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_disable | input | 1 | 1: every access goes to memory |
| ctl_wback | input | 1 | 1: write-back, 0: write-through |
| cmd_inval | input | 1 | Drop all lines, no write-back |
| cmd_flush | input | 1 | Write modified lines, then drop all |
| cpu_req | input | 1 | Request, taken when cpu_ready is high |
| cpu_we | input | 1 | 1: write, 0: read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | Block can take a request or command |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: memory write |
| mem_addr | output | ADDR_W-2 | Line (32-bit word) address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access done, read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
A wrong tag, valid bit or set index does not always return bad data at once. It shows as a surplus or a missing memory read on the next access to that line, so the bench counts memory reads and writes per request as well as comparing every returned byte. A lost dirty bit stays hidden until eviction or flush. At that point the refetched byte or the final memory image comparison exposes it. A recency bit that is off by one way shows within two conflicting reads, as a miss where a hit belongs.

// File: rtl/tsac_pkg.sv
package tsac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITEBACK,
    ST_FILL,
    ST_RESPOND,
    ST_MEMOP,
    ST_FLUSH
  } tsac_state_t;

  // pick byte `ofs` of a 32-bit line (byte 0 = bits 7:0)
  function automatic logic [7:0] line_byte(input logic [31:0] line, input logic [1:0] ofs);
    return line[ofs*8 +: 8];
  endfunction

  // replace byte `ofs` of a line
  function automatic logic [31:0] line_merge(input logic [31:0] line, input logic [1:0] ofs,
                                             input logic [7:0] val);
    logic [31:0] res;
    res = line;
    res[ofs*8 +: 8] = val;
    return res;
  endfunction

  // single byte enable for a byte offset
  function automatic logic [3:0] byte_en(input logic [1:0] ofs);
    return 4'b0001 << ofs;
  endfunction

endpackage

// File: rtl/tsac_store.sv
module tsac_store #(
  parameter int SET_W = 4,
  parameter int TAG_W = 18
) (
  input  logic                      clk,
  input  logic                      rst_n,
  // lookup
  input  logic [SET_W-1:0]          lk_set,
  input  logic [TAG_W-1:0]          lk_tag,
  output logic [1:0]                lk_hit,
  output logic [1:0]                lk_valid,
  output logic [1:0]                lk_dirty,
  output logic [1:0][TAG_W-1:0]     lk_tagq,
  output logic [1:0][31:0]          lk_line,
  output logic                      lk_use,
  // line fill
  input  logic                      ln_we,
  input  logic [SET_W-1:0]          ln_set,
  input  logic                      ln_way,
  input  logic [TAG_W-1:0]          ln_tag,
  input  logic [31:0]               ln_data,
  // byte write
  input  logic                      by_we,
  input  logic [SET_W-1:0]          by_set,
  input  logic                      by_way,
  input  logic [1:0]                by_ofs,
  input  logic [7:0]                by_val,
  input  logic                      by_dirty,
  // recency update
  input  logic                      use_we,
  input  logic [SET_W-1:0]          use_set,
  input  logic                      use_way,
  // dirty clear after flush write
  input  logic                      dc_we,
  input  logic [SET_W-1:0]          dc_set,
  input  logic                      dc_way,
  // drop everything
  input  logic                      inv_all
);
  import tsac_pkg::*;

  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0][1:0] valid_q;
  logic [SETS-1:0][1:0] dirty_q;
  logic [SETS-1:0]      use_q;     // way referenced last
  logic [TAG_W-1:0]     tag_q  [SETS][2];
  logic [31:0]          data_q [SETS][2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      use_q   <= '0;
    end else begin
      if (ln_we) begin
        valid_q[ln_set][ln_way] <= 1'b1;
        dirty_q[ln_set][ln_way] <= 1'b0;
      end
      if (by_we && by_dirty) dirty_q[by_set][by_way] <= 1'b1;
      if (dc_we)             dirty_q[dc_set][dc_way] <= 1'b0;
      if (use_we)            use_q[use_set]          <= use_way;
      if (inv_all) begin
        valid_q <= '0;
        dirty_q <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ln_we) begin
      tag_q[ln_set][ln_way]  <= ln_tag;
      data_q[ln_set][ln_way] <= ln_data;
    end
    if (by_we) data_q[by_set][by_way] <= line_merge(data_q[by_set][by_way], by_ofs, by_val);
  end

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign lk_valid[w] = valid_q[lk_set][w];
    assign lk_dirty[w] = dirty_q[lk_set][w];
    assign lk_tagq[w]  = tag_q[lk_set][w];
    assign lk_line[w]  = data_q[lk_set][w];
    assign lk_hit[w]   = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end
  assign lk_use = use_q[lk_set];

  // R3
  dual_hit_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lk_hit))
    else $error("both ways hit one address");

  // R9
  inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0))
    else $error("valid bits survive invalidate");

  // R4
  use_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    use_we |=> (use_q[$past(use_set)] == $past(use_way)))
    else $error("recency bit not updated");

endmodule

// File: rtl/tsac_ctrl.sv
module tsac_ctrl #(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 4,
  localparam int OFS_W = 2,
  localparam int TAG_W = ADDR_W - SET_W - OFS_W,
  localparam int LA_W  = ADDR_W - OFS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_disable,
  input  logic                  ctl_wback,
  input  logic                  cmd_inval,
  input  logic                  cmd_flush,
  input  logic                  cpu_req,
  input  logic                  cpu_we,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [7:0]            cpu_wdata,
  output logic                  cpu_ready,
  output logic                  rsp_valid,
  output logic [7:0]            rsp_data,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [LA_W-1:0]       mem_addr,
  output logic [3:0]            mem_be,
  output logic [31:0]           mem_wdata,
  input  logic                  mem_ack,
  input  logic [31:0]           mem_rdata,
  // store lookup
  output logic [SET_W-1:0]      lk_set,
  output logic [TAG_W-1:0]      lk_tag,
  input  logic [1:0]            lk_hit,
  input  logic [1:0]            lk_valid,
  input  logic [1:0]            lk_dirty,
  input  logic [1:0][TAG_W-1:0] lk_tagq,
  input  logic [1:0][31:0]      lk_line,
  input  logic                  lk_use,
  // store updates
  output logic                  ln_we,
  output logic [SET_W-1:0]      ln_set,
  output logic                  ln_way,
  output logic [TAG_W-1:0]      ln_tag,
  output logic [31:0]           ln_data,
  output logic                  by_we,
  output logic [SET_W-1:0]      by_set,
  output logic                  by_way,
  output logic [1:0]            by_ofs,
  output logic [7:0]            by_val,
  output logic                  by_dirty,
  output logic                  use_we,
  output logic [SET_W-1:0]      use_set,
  output logic                  use_way,
  output logic                  dc_we,
  output logic [SET_W-1:0]      dc_set,
  output logic                  dc_way,
  output logic                  inv_all
);
  import tsac_pkg::*;

  localparam int IDX_W = SET_W + 1;   // flush walks every set and way

  // address field helpers
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [SET_W-1:0] f_set(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: SET_W];
  endfunction
  function automatic logic [OFS_W-1:0] f_ofs(input logic [ADDR_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction
  function automatic logic [LA_W-1:0] f_line(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  tsac_state_t        st_q, st_d;
  logic               r_we;
  logic [ADDR_W-1:0]  r_addr;
  logic [7:0]         r_wdata;
  logic               r_vict;
  logic [IDX_W-1:0]   idx_q;
  logic               rsp_valid_q;
  logic [7:0]         rsp_data_q;

  // named events
  logic in_idle, accept, hit_any, hit_way, vict_way, vict_dirty;
  logic acc_bypass, acc_rd_hit, acc_wr_hit, acc_miss;
  logic fl_way, fl_dirty, fl_last, fl_step;
  logic start_flush, start_inval;

  assign in_idle     = (st_q == ST_IDLE);
  assign cpu_ready   = in_idle && !cmd_inval && !cmd_flush;
  assign accept      = cpu_ready && cpu_req;
  assign start_flush = in_idle && cmd_flush;
  assign start_inval = in_idle && cmd_inval && !cmd_flush;

  always_comb begin
    unique case (st_q)
      ST_IDLE:  begin lk_set = f_set(cpu_addr);      lk_tag = f_tag(cpu_addr); end
      ST_FLUSH: begin lk_set = idx_q[IDX_W-1:1];     lk_tag = f_tag(r_addr);   end
      default:  begin lk_set = f_set(r_addr);        lk_tag = f_tag(r_addr);   end
    endcase
  end

  assign hit_any    = |lk_hit;
  assign hit_way    = lk_hit[1];
  assign vict_way   = ~lk_use;
  assign vict_dirty = lk_valid[vict_way] && lk_dirty[vict_way];

  assign acc_bypass = accept && ctl_disable;
  assign acc_rd_hit = accept && !ctl_disable && !cpu_we && hit_any;
  assign acc_wr_hit = accept && !ctl_disable && cpu_we && hit_any;
  assign acc_miss   = accept && !ctl_disable && !hit_any;

  assign fl_way   = idx_q[0];
  assign fl_dirty = lk_valid[fl_way] && lk_dirty[fl_way];
  assign fl_last  = (idx_q == {IDX_W{1'b1}});
  assign fl_step  = (st_q == ST_FLUSH) && (!fl_dirty || mem_ack);

  // store update drive
  always_comb begin
    use_we   = acc_rd_hit || acc_wr_hit || ((st_q == ST_FILL) && mem_ack);
    use_set  = lk_set;
    use_way  = in_idle ? hit_way : r_vict;

    by_we    = acc_wr_hit || ((st_q == ST_RESPOND) && r_we);
    by_set   = lk_set;
    by_way   = in_idle ? hit_way : r_vict;
    by_ofs   = in_idle ? f_ofs(cpu_addr) : f_ofs(r_addr);
    by_val   = in_idle ? cpu_wdata : r_wdata;
    by_dirty = ctl_wback;

    ln_we    = (st_q == ST_FILL) && mem_ack;
    ln_set   = lk_set;
    ln_way   = r_vict;
    ln_tag   = f_tag(r_addr);
    ln_data  = mem_rdata;

    dc_we    = (st_q == ST_FLUSH) && mem_ack;
    dc_set   = lk_set;
    dc_way   = fl_way;

    inv_all  = start_inval || (fl_step && fl_last);
  end

  // memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = f_line(r_addr);
    mem_be    = 4'hF;
    mem_wdata = lk_line[r_vict];
    unique case (st_q)
      ST_WRITEBACK: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {lk_tagq[r_vict], f_set(r_addr)};
      end
      ST_FILL: mem_req = 1'b1;
      ST_MEMOP: begin
        mem_req   = 1'b1;
        mem_we    = r_we;
        mem_wdata = {4{r_wdata}};
        mem_be    = r_we ? byte_en(f_ofs(r_addr)) : 4'hF;
      end
      ST_FLUSH: begin
        mem_req   = fl_dirty;
        mem_we    = 1'b1;
        mem_addr  = {lk_tagq[fl_way], idx_q[IDX_W-1:1]};
        mem_wdata = lk_line[fl_way];
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_flush)                    st_d = ST_FLUSH;
        else if (acc_bypass)                st_d = ST_MEMOP;
        else if (acc_wr_hit && !ctl_wback)  st_d = ST_MEMOP;
        else if (acc_miss)                  st_d = vict_dirty ? ST_WRITEBACK : ST_FILL;
      end
      ST_WRITEBACK: if (mem_ack) st_d = ST_FILL;
      ST_FILL:      if (mem_ack) st_d = ST_RESPOND;
      ST_RESPOND:   st_d = (r_we && !ctl_wback) ? ST_MEMOP : ST_IDLE;
      ST_MEMOP:     if (mem_ack) st_d = ST_IDLE;
      ST_FLUSH:     if (fl_step && fl_last) st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      r_we        <= 1'b0;
      r_addr      <= '0;
      r_wdata     <= '0;
      r_vict      <= 1'b0;
      idx_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      st_q        <= st_d;
      rsp_valid_q <= 1'b0;
      if (accept) begin
        r_we    <= cpu_we;
        r_addr  <= cpu_addr;
        r_wdata <= cpu_wdata;
        r_vict  <= vict_way;
      end
      if (start_flush) idx_q <= '0;
      else if (fl_step && !fl_last) idx_q <= idx_q + 1'b1;
      if (acc_rd_hit) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= line_byte(lk_line[hit_way], f_ofs(cpu_addr));
      end else if ((st_q == ST_RESPOND) && !r_we) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= line_byte(lk_line[r_vict], f_ofs(r_addr));
      end else if ((st_q == ST_MEMOP) && mem_ack && !r_we) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= line_byte(mem_rdata, f_ofs(r_addr));
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)))
    else $error("memory request dropped or changed before ack");

  // R2
  hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd_hit |=> (rsp_valid && !mem_req))
    else $error("read hit not answered next cycle");

  // R5
  wb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr_hit && ctl_wback) |=> !mem_req)
    else $error("write-back hit touched memory");

  // R6
  evict_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WRITEBACK) && mem_ack) |=> (st_q == ST_FILL && mem_req && !mem_we))
    else $error("fill does not follow victim write");

endmodule

// File: rtl/tsac_cache.sv
module tsac_cache #(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 4,
  localparam int TAG_W = ADDR_W - SET_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_disable,
  input  logic              ctl_wback,
  input  logic              cmd_inval,
  input  logic              cmd_flush,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic              cpu_ready,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);

  logic [SET_W-1:0]      lk_set;
  logic [TAG_W-1:0]      lk_tag;
  logic [1:0]            lk_hit, lk_valid, lk_dirty;
  logic [1:0][TAG_W-1:0] lk_tagq;
  logic [1:0][31:0]      lk_line;
  logic                  lk_use;
  logic                  ln_we, ln_way;
  logic [SET_W-1:0]      ln_set;
  logic [TAG_W-1:0]      ln_tag;
  logic [31:0]           ln_data;
  logic                  by_we, by_way, by_dirty;
  logic [SET_W-1:0]      by_set;
  logic [1:0]            by_ofs;
  logic [7:0]            by_val;
  logic                  use_we, use_way;
  logic [SET_W-1:0]      use_set;
  logic                  dc_we, dc_way;
  logic [SET_W-1:0]      dc_set;
  logic                  inv_all;

  tsac_ctrl #(.ADDR_W(ADDR_W), .SET_W(SET_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctl_disable(ctl_disable), .ctl_wback(ctl_wback),
    .cmd_inval(cmd_inval), .cmd_flush(cmd_flush),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .lk_set(lk_set), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_valid(lk_valid),
    .lk_dirty(lk_dirty), .lk_tagq(lk_tagq), .lk_line(lk_line), .lk_use(lk_use),
    .ln_we(ln_we), .ln_set(ln_set), .ln_way(ln_way), .ln_tag(ln_tag), .ln_data(ln_data),
    .by_we(by_we), .by_set(by_set), .by_way(by_way), .by_ofs(by_ofs), .by_val(by_val),
    .by_dirty(by_dirty),
    .use_we(use_we), .use_set(use_set), .use_way(use_way),
    .dc_we(dc_we), .dc_set(dc_set), .dc_way(dc_way),
    .inv_all(inv_all)
  );

  tsac_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_set(lk_set), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_valid(lk_valid),
    .lk_dirty(lk_dirty), .lk_tagq(lk_tagq), .lk_line(lk_line), .lk_use(lk_use),
    .ln_we(ln_we), .ln_set(ln_set), .ln_way(ln_way), .ln_tag(ln_tag), .ln_data(ln_data),
    .by_we(by_we), .by_set(by_set), .by_way(by_way), .by_ofs(by_ofs), .by_val(by_val),
    .by_dirty(by_dirty),
    .use_we(use_we), .use_set(use_set), .use_way(use_way),
    .dc_we(dc_we), .dc_set(dc_set), .dc_way(dc_way),
    .inv_all(inv_all)
  );

endmodule

// File: tb/tsac_cache_tb.sv
`timescale 1ns/1ps
module tsac_cache_tb;

  localparam int ADDR_W = 24;
  localparam int SET_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_disable = 1'b0, ctl_wback = 1'b1, cmd_inval = 1'b0, cmd_flush = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_ready, rsp_valid, mem_req, mem_we;
  logic [7:0] rsp_data;
  logic [ADDR_W-3:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;   // 50 MHz

  tsac_cache #(.ADDR_W(ADDR_W), .SET_W(SET_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_disable(ctl_disable), .ctl_wback(ctl_wback),
    .cmd_inval(cmd_inval), .cmd_flush(cmd_flush), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;
  int n_memrd = 0, n_memwr = 0, hold_err = 0;
  logic [3:0] last_be = '0;
  logic [31:0] mem_w [int];
  logic [7:0]  ref_b [int];
  logic [7:0]  exp_q [$];
  string       tag_q [$];

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input int w);
    if (mem_w.exists(w)) return mem_w[w];
    return (w * 32'h9E3779B1) ^ 32'h5A3C_C3A5;
  endfunction

  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    logic [31:0] w;
    w = mem_word(int'(a >> 2));
    return w[a[1:0]*8 +: 8];
  endfunction

  function automatic logic [7:0] ref_byte(input logic [ADDR_W-1:0] a);
    if (ref_b.exists(int'(a))) return ref_b[int'(a)];
    return mem_byte(a);
  endfunction

  // byte address from fields: tag | set | offset
  function automatic logic [ADDR_W-1:0] mk(input int tg, input int st, input int of);
    logic [ADDR_W-1:0] a;
    a = {tg[ADDR_W-SET_W-3:0], st[SET_W-1:0], of[1:0]};
    return a;
  endfunction

  // memory model: ack one cycle after a request is seen
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      logic [31:0] cur;
      mem_ack <= 1'b1;
      cur = mem_word(int'(mem_addr));
      if (mem_we) begin
        for (int b = 0; b < 4; b++) if (mem_be[b]) cur[b*8 +: 8] = mem_wdata[b*8 +: 8];
        mem_w[int'(mem_addr)] = cur;
        n_memwr++;
        last_be = mem_be;
      end else begin
        mem_rdata <= cur;
        n_memrd++;
      end
    end else mem_ack <= 1'b0;
  end

  // request hold monitor (R12)
  logic pend_q = 1'b0;
  always @(negedge clk) begin
    if (rst_n && pend_q && !mem_req) hold_err++;
    pend_q <= rst_n && mem_req && !mem_ack;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check("R1 unexpected response", {24'd0, rsp_data}, 32'hFFFF_FFFF);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {24'd0, rsp_data}, {24'd0, e});
      end
    end
  end

  task automatic do_acc(input bit we, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                        input string tg);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    if (!we) begin
      exp_q.push_back(ref_byte(a));
      tag_q.push_back(tg);
    end else ref_b[int'(a)] = d;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    while (!(cpu_ready && exp_q.size() == 0 && !mem_req)) @(negedge clk);
  endtask

  task automatic do_cmd(input bit flush);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    if (flush) cmd_flush = 1'b1; else cmd_inval = 1'b1;
    @(negedge clk);
    cmd_flush = 1'b0; cmd_inval = 1'b0;
    settle();
    if (!flush) foreach (ref_b[k]) ref_b[k] = mem_byte(k[ADDR_W-1:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int rd0, wr0;
    logic [ADDR_W-1:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 ready", cpu_ready, 1);
    check("R11 mem_req", mem_req, 0);
    check("R11 rsp_valid", rsp_valid, 0);

    // R3 first access misses and fills the line
    rd0 = n_memrd;
    do_acc(0, mk(5, 3, 1), 0, "R1 miss data");
    check("R3 ready low during miss", cpu_ready, 0);
    settle();
    check("R3 one fill read", n_memrd - rd0, 1);

    // R2 hit in same line
    rd0 = n_memrd;
    do_acc(0, mk(5, 3, 2), 0, "R2 hit data");
    check("R2 rsp next cycle", rsp_valid, 1);
    check("R2 ready stays high", cpu_ready, 1);
    settle();
    check("R2 no memory access", n_memrd - rd0, 0);

    // R1 every byte of the line, then same tag in another set
    for (int o = 0; o < 4; o++) do_acc(0, mk(5, 3, o), 0, "R1 byte select");
    settle();
    rd0 = n_memrd;
    do_acc(0, mk(5, 4, 0), 0, "R1 other set data");
    settle();
    check("R1 other set misses", n_memrd - rd0, 1);

    // R4 recency replacement in set 7
    do_acc(0, mk(1, 7, 0), 0, "R4 data");
    do_acc(0, mk(2, 7, 0), 0, "R4 data");
    do_acc(0, mk(1, 7, 1), 0, "R4 data");
    do_acc(0, mk(3, 7, 0), 0, "R4 data");
    settle();
    rd0 = n_memrd;
    do_acc(0, mk(1, 7, 2), 0, "R4 data");
    settle();
    check("R4 recent line kept", n_memrd - rd0, 0);
    rd0 = n_memrd;
    do_acc(0, mk(2, 7, 0), 0, "R4 data");
    settle();
    check("R4 older line replaced", n_memrd - rd0, 1);

    // R5 write-back hit
    wr0 = n_memwr;
    do_acc(1, mk(5, 3, 1), 8'hC7, "");
    settle();
    check("R5 no memory write", n_memwr - wr0, 0);
    do_acc(0, mk(5, 3, 1), 0, "R5 readback");
    settle();

    // R6 dirty victim eviction
    do_acc(0, mk(6, 3, 0), 0, "R6 data");
    settle();
    wr0 = n_memwr; rd0 = n_memrd;
    do_acc(0, mk(7, 3, 0), 0, "R6 data");
    settle();
    check("R6 one victim write", n_memwr - wr0, 1);
    check("R6 full line enables", last_be, 4'hF);
    check("R6 one fill read", n_memrd - rd0, 1);
    check("R6 memory holds byte", mem_byte(mk(5, 3, 1)), 8'hC7);
    do_acc(0, mk(5, 3, 1), 0, "R6 refetch");
    settle();

    // R10 flush
    do_acc(1, mk(9, 10, 0), 8'h11, "");
    do_acc(1, mk(9, 11, 3), 8'h22, "");
    do_acc(0, mk(9, 12, 0), 0, "R10 data");
    settle();
    do_cmd(1);   // clean out earlier dirty lines too
    do_acc(1, mk(9, 10, 0), 8'h33, "");
    do_acc(1, mk(9, 11, 3), 8'h44, "");
    do_acc(0, mk(9, 12, 1), 0, "R10 data");
    settle();
    wr0 = n_memwr;
    do_cmd(1);
    check("R10 only dirty lines written", n_memwr - wr0, 2);
    rd0 = n_memrd;
    do_acc(0, mk(9, 10, 0), 0, "R10 flushed data");
    settle();
    check("R10 lines invalid after flush", n_memrd - rd0, 1);

    // R9 invalidate discards modified data
    a = mk(12, 13, 2);
    do_acc(1, a, 8'h5A, "");
    settle();
    wr0 = n_memwr;
    do_cmd(0);
    check("R9 no write on invalidate", n_memwr - wr0, 0);
    rd0 = n_memrd;
    do_acc(0, a, 0, "R9 memory contents");
    settle();
    check("R9 miss after invalidate", n_memrd - rd0, 1);

    // R7 write-through
    @(negedge clk); ctl_wback = 1'b0;
    do_acc(0, mk(4, 2, 3), 0, "R7 data");
    settle();
    wr0 = n_memwr;
    do_acc(1, mk(4, 2, 3), 8'h3C, "");
    settle();
    check("R7 write hit to memory", n_memwr - wr0, 1);
    check("R7 byte enable", last_be, 4'b1000);
    check("R7 memory byte", mem_byte(mk(4, 2, 3)), 8'h3C);
    wr0 = n_memwr; rd0 = n_memrd;
    do_acc(1, mk(4, 5, 1), 8'h77, "");
    settle();
    check("R7 write miss fill", n_memrd - rd0, 1);
    check("R7 write miss to memory", n_memwr - wr0, 1);
    do_acc(0, mk(4, 5, 1), 0, "R7 readback");
    settle();

    // R8 cache disabled
    do_cmd(1);
    @(negedge clk); ctl_disable = 1'b1; ctl_wback = 1'b1;
    rd0 = n_memrd;
    do_acc(0, mk(4, 2, 3), 0, "R8 bypass data");
    do_acc(0, mk(4, 2, 3), 0, "R8 bypass data");
    settle();
    check("R8 every read to memory", n_memrd - rd0, 2);
    wr0 = n_memwr;
    do_acc(1, mk(4, 2, 3), 8'h99, "");
    settle();
    check("R8 write to memory", n_memwr - wr0, 1);
    do_acc(0, mk(4, 2, 3), 0, "R8 bypass readback");
    settle();
    @(negedge clk); ctl_disable = 1'b0;
    do_cmd(0);

    // mixed traffic with heavy set conflicts
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] ra;
      ra = mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
      if (i % 97 == 50) begin @(negedge clk); ctl_wback = ~ctl_wback; end
      if ($urandom_range(0, 9) < 3) do_acc(1, ra, 8'($urandom), "");
      else do_acc(0, ra, 0, "R4 R5 R6 mixed data");
    end
    settle();
    do_cmd(1);
    begin
      int bad;
      bad = 0;
      foreach (ref_b[k]) if (mem_byte(k[ADDR_W-1:0]) !== ref_b[k]) bad++;
      check("R10 memory image after flush", bad, 0);
    end
    check("R12 request held until ack", hold_err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule